// File: doc/BRIEF.md
# Priority Video Source Selector

This block picks one of three 23-signal video/audio source buses (A, B, C) and passes it to a single output bus. Sources A and B share one activity flag and a socket-pick input. Source C has its own valid flag. Two configuration straps are read from the A/B pins while reset is held:

- One strap decides whether C or the A/B pair wins when both are valid.
- The other strap decides whether an idle output bus is released or driven low.

The selection is combinational. Data, the per-bus drive enable and the status flag follow the inputs in the same cycle. An active-low output enable forces the bus into its idle state. The output is modelled as a data vector plus a single drive enable, not as a real tristate.

Bus layout, least significant bit first:

| Bits | Signal |
|------|--------|
| [7:0] | luma |
| [15:8] | chroma |
| 16 | horizontal reference |
| 17 | vertical sync |
| 18 | pixel clock |
| 19 | serial audio bit clock |
| 20 | audio master clock |
| 21 | left/right clock |
| 22 | audio data |

The block only routes whole buses. The layout is therefore a naming convention, not a behaviour.

Top module: `zv_switch3`

## Requirements
- R1: When a source is selected, its full 23-bit bus appears unchanged on `zv_out` in the same cycle, and changes on that source bus pass through with no clock delay.
- R2: With `ab_active` high, `ab_pick_a` high selects A and low selects B. With `ab_active` low, `ab_pick_a` has no effect on the output.
- R3: With the precedence strap set (`ab_pick_a` high at reset), C is selected whenever `c_valid` is high. A/B is selected only when `c_valid` is low and `ab_active` is high.
- R4: With the precedence strap clear (`ab_pick_a` low at reset), A/B is selected whenever `ab_active` is high. C is selected only when `ab_active` is low and `c_valid` is high.
- R5: When `out_en_n` is high, or when neither `ab_active` nor `c_valid` is high, the output is in its idle state whatever the other inputs are.
- R6: If `ab_active` was high at reset, the idle state has `zv_drive` low. Otherwise the idle state has `zv_drive` high and `zv_out` all zeros.
- R7: While `rst_n` is low, `zv_drive`, `zv_busy` and `zv_out` are all low, even with valid sources and `out_en_n` low.
- R8: `zv_busy` is high exactly when a selected source is being driven. Whenever it is high, `zv_drive` is high too.
- R9: Both straps take the pin levels seen at the last rising clock edge with `rst_n` low. After reset they keep those values whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for strap capture |
| rst_n | input | 1 | Reset, active low |
| src_a | input | 23 | Source bus A |
| src_b | input | 23 | Source bus B |
| src_c | input | 23 | Source bus C |
| ab_active | input | 1 | A/B source active; idle strap during reset |
| ab_pick_a | input | 1 | 1 = A, 0 = B; precedence strap during reset |
| c_valid | input | 1 | Source C carries valid data |
| out_en_n | input | 1 | Output enable, active low |
| zv_out | output | 23 | Selected output bus data |
| zv_drive | output | 1 | Output bus drive enable |
| zv_busy | output | 1 | High while a source is driven |

## Verification
All sixteen combinations of the A/B activity flag, the socket pick, the C valid flag and the output enable are applied under each of the four strap settings. This separates:

- a wrong precedence order from a wrong socket decode;
- a released idle bus from a bus driven low.

Distinct bit patterns on A, B and C make any mix-up of sources visible on the data bus. Directed cases then:

- hold valid sources during reset, to confirm every output stays quiet;
- toggle the strap pins during and after reset, to confirm that the last in-reset level is kept;
- change a selected source mid-cycle, to prove pass-through with no delay.

// File: rtl/zv_sw_pkg.sv
package zv_sw_pkg;

    localparam int LUMA_W   = 8;
    localparam int CHROMA_W = 8;

    // Bit 0 upward: luma, chroma, href, vsync, pclk, sclk, mclk, lrclk, sdata
    typedef struct packed {
        logic                sdata;
        logic                lrclk;
        logic                mclk;
        logic                sclk;
        logic                pclk;
        logic                vsync;
        logic                href;
        logic [CHROMA_W-1:0] chroma;
        logic [LUMA_W-1:0]   luma;
    } zv_bus_t;

    localparam int BUS_W = $bits(zv_bus_t);

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_A    = 2'd1,
        SRC_B    = 2'd2,
        SRC_C    = 2'd3
    } zv_src_e;

    typedef struct packed {
        logic c_first;       // C outranks the A/B pair
        logic idle_release;  // idle bus is released rather than driven low
    } zv_strap_t;

    function automatic zv_src_e zv_pick(
        input logic ab_act,
        input logic pick_a,
        input logic c_ok,
        input logic oe_n,
        input logic c_first
    );
        zv_src_e ab_src;
        zv_src_e res;
        ab_src = pick_a ? SRC_A : SRC_B;
        res    = SRC_NONE;
        if (!oe_n) begin
            if (c_first) begin
                if (c_ok)        res = SRC_C;
                else if (ab_act) res = ab_src;
            end else begin
                if (ab_act)      res = ab_src;
                else if (c_ok)   res = SRC_C;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/zv_strap_latch.sv
module zv_strap_latch
    import zv_sw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_idle,
    input  logic      pin_prec,
    output zv_strap_t strap
);

    zv_strap_t strap_q;

    // Sample the pins on every edge inside reset, freeze afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q.idle_release <= pin_idle;
            strap_q.c_first      <= pin_prec;
        end
    end

    assign strap = strap_q;

    assert_strap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(strap_q.c_first) && $stable(strap_q.idle_release)));

endmodule

// File: rtl/zv_arbiter.sv
module zv_arbiter
    import zv_sw_pkg::*;
(
    input  logic      ab_active,
    input  logic      ab_pick_a,
    input  logic      c_valid,
    input  logic      out_en_n,
    input  zv_strap_t strap,
    output zv_src_e   sel
);

    always_comb begin
        sel = zv_pick(ab_active, ab_pick_a, c_valid, out_en_n, strap.c_first);
    end

endmodule

// File: rtl/zv_drive_stage.sv
module zv_drive_stage
    import zv_sw_pkg::*;
(
    input  logic    rst_n,
    input  zv_src_e sel,
    input  logic    idle_release,
    input  zv_bus_t bus_a,
    input  zv_bus_t bus_b,
    input  zv_bus_t bus_c,
    output zv_bus_t bus_o,
    output logic    drive,
    output logic    busy
);

    zv_bus_t picked;

    always_comb begin
        unique case (sel)
            SRC_A:   picked = bus_a;
            SRC_B:   picked = bus_b;
            SRC_C:   picked = bus_c;
            default: picked = '0;
        endcase
    end

    always_comb begin
        if (!rst_n) begin
            bus_o = '0;
            drive = 1'b0;
            busy  = 1'b0;
        end else if (sel != SRC_NONE) begin
            bus_o = picked;
            drive = 1'b1;
            busy  = 1'b1;
        end else begin
            bus_o = '0;
            drive = !idle_release;
            busy  = 1'b0;
        end
    end

endmodule

// File: rtl/zv_switch3.sv
module zv_switch3
    import zv_sw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] src_a,
    input  logic [BUS_W-1:0] src_b,
    input  logic [BUS_W-1:0] src_c,
    input  logic             ab_active,
    input  logic             ab_pick_a,
    input  logic             c_valid,
    input  logic             out_en_n,
    output logic [BUS_W-1:0] zv_out,
    output logic             zv_drive,
    output logic             zv_busy
);

    zv_strap_t strap;
    zv_src_e   sel;
    zv_bus_t   bus_o;

    zv_strap_latch u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_idle (ab_active),
        .pin_prec (ab_pick_a),
        .strap    (strap)
    );

    zv_arbiter u_arb (
        .ab_active (ab_active),
        .ab_pick_a (ab_pick_a),
        .c_valid   (c_valid),
        .out_en_n  (out_en_n),
        .strap     (strap),
        .sel       (sel)
    );

    zv_drive_stage u_out (
        .rst_n        (rst_n),
        .sel          (sel),
        .idle_release (strap.idle_release),
        .bus_a        (zv_bus_t'(src_a)),
        .bus_b        (zv_bus_t'(src_b)),
        .bus_c        (zv_bus_t'(src_c)),
        .bus_o        (bus_o),
        .drive        (zv_drive),
        .busy         (zv_busy)
    );

    assign zv_out = bus_o;

    assert_reset_quiet_R7: assert property (@(posedge clk)
        !rst_n |-> (!zv_drive && !zv_busy && zv_out == '0));

    assert_busy_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
        zv_busy |-> zv_drive);

    assert_oe_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !zv_busy);

    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!zv_busy && zv_drive) |-> (zv_out == '0));

    assert_pick_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_active && !out_en_n && c_valid) |-> (zv_out == src_c));

    assert_c_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strap.c_first && c_valid && !out_en_n) |-> (zv_out == src_c && zv_busy));

    assert_ab_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strap.c_first && ab_active && ab_pick_a && !out_en_n) |-> (zv_out == src_a && zv_busy));

endmodule

// File: tb/zv_switch3_test.sv
module zv_switch3_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 23;

    localparam logic [W-1:0] PAT_A = 23'h5A_3C_C3;
    localparam logic [W-1:0] PAT_B = 23'h25_96_69;
    localparam logic [W-1:0] PAT_C = 23'h71_E1_1E;

    // {ab_active, ab_pick_a, c_valid, out_en_n, exp_ab_first[1:0], exp_c_first[1:0]}
    // source code: 0 none, 1 A, 2 B, 3 C
    localparam logic [7:0] VEC [16] = '{
        8'b0000_00_00, 8'b0001_00_00, 8'b0010_11_11, 8'b0011_00_00,
        8'b0100_00_00, 8'b0101_00_00, 8'b0110_11_11, 8'b0111_00_00,
        8'b1000_10_10, 8'b1001_00_00, 8'b1010_10_11, 8'b1011_00_00,
        8'b1100_01_01, 8'b1101_00_00, 8'b1110_01_11, 8'b1111_00_00
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] src_a = PAT_A, src_b = PAT_B, src_c = PAT_C;
    logic         ab_active = 1'b0, ab_pick_a = 1'b0, c_valid = 1'b0, out_en_n = 1'b1;
    logic [W-1:0] zv_out;
    logic         zv_drive, zv_busy;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zv_switch3 uut (
        .clk (clk), .rst_n (rst_n),
        .src_a (src_a), .src_b (src_b), .src_c (src_c),
        .ab_active (ab_active), .ab_pick_a (ab_pick_a),
        .c_valid (c_valid), .out_en_n (out_en_n),
        .zv_out (zv_out), .zv_drive (zv_drive), .zv_busy (zv_busy)
    );

    task automatic check(input string req, input logic [W-1:0] ed,
                         input logic edrv, input logic ebusy);
        checks++;
        if (zv_out !== ed || zv_drive !== edrv || zv_busy !== ebusy) begin
            errors++;
            $display("FAIL %s: out=%h drive=%b busy=%b expected out=%h drive=%b busy=%b",
                     req, zv_out, zv_drive, zv_busy, ed, edrv, ebusy);
        end
    endtask

    task automatic expect_src(input string req, input logic [1:0] code, input logic idle_rel);
        case (code)
            2'd1:    check(req, src_a, 1'b1, 1'b1);
            2'd2:    check(req, src_b, 1'b1, 1'b1);
            2'd3:    check(req, src_c, 1'b1, 1'b1);
            default: check(req, '0, !idle_rel, 1'b0);
        endcase
    endtask

    // Reset with given strap pin levels, release afterwards
    task automatic do_reset(input logic idle_pin, input logic prec_pin);
        @(negedge clk);
        rst_n = 1'b0; ab_active = idle_pin; ab_pick_a = prec_pin;
        c_valid = 1'b1; out_en_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R7: in reset, valid sources and enable asserted, outputs stay quiet
        repeat (2) @(negedge clk);
        ab_active = 1'b1; ab_pick_a = 1'b1; c_valid = 1'b1; out_en_n = 1'b0;
        #1 check("R7 reset quiet", '0, 1'b0, 1'b0);

        // Table walk under all four strap settings
        for (int s = 0; s < 4; s++) begin
            logic idle_pin, prec_pin;
            idle_pin = s[1];
            prec_pin = s[0];
            do_reset(idle_pin, prec_pin);
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                {ab_active, ab_pick_a, c_valid, out_en_n} = VEC[i][7:4];
                #1;
                if (prec_pin)
                    expect_src("R3/R2/R5/R6/R8 c-first table", VEC[i][1:0], idle_pin);
                else
                    expect_src("R4/R2/R5/R6/R8 ab-first table", VEC[i][3:2], idle_pin);
            end
        end

        // R9: last in-reset level wins; pins toggle after reset without effect
        @(negedge clk);
        rst_n = 1'b0; ab_active = 1'b1; ab_pick_a = 1'b1;
        @(negedge clk);
        ab_active = 1'b0; ab_pick_a = 1'b0;   // last sampled: driven idle, A/B first
        @(negedge clk);
        rst_n = 1'b1;
        ab_active = 1'b1; ab_pick_a = 1'b1; c_valid = 1'b1; out_en_n = 1'b0;
        #1 check("R9 last reset level, A/B first", PAT_A, 1'b1, 1'b1);
        @(negedge clk);
        ab_active = 1'b0; c_valid = 1'b0;
        #1 check("R9 idle strap kept (driven low)", '0, 1'b1, 1'b0);

        // R2: pick toggles while A/B inactive, C on output unchanged
        @(negedge clk);
        c_valid = 1'b1; ab_pick_a = 1'b0;
        #1 check("R2 pick ignored lo", PAT_C, 1'b1, 1'b1);
        ab_pick_a = 1'b1;
        #1 check("R2 pick ignored hi", PAT_C, 1'b1, 1'b1);

        // R1: source change passes through in the same cycle
        @(negedge clk);
        ab_active = 1'b1; ab_pick_a = 1'b0;
        #1 check("R1 B selected", PAT_B, 1'b1, 1'b1);
        src_b = 23'h7F_FF_FF;
        #1 check("R1 B all ones passes", 23'h7F_FF_FF, 1'b1, 1'b1);
        src_b = 23'h40_00_01;
        #1 check("R1 B edge bits pass", 23'h40_00_01, 1'b1, 1'b1);

        // R5: enable off with every source valid
        out_en_n = 1'b1;
        #1 check("R5 enable off idles", '0, 1'b1, 1'b0);

        // R7: re-entering reset releases immediately
        @(negedge clk);
        out_en_n = 1'b0; rst_n = 1'b0;
        #1 check("R7 reset re-entry quiet", '0, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule